// File: doc/BRIEF.md
# Flow-Through Zero-Turnaround Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous static RAM that takes address and control on the rising clock edge. It presents read data in the same cycle as the registered address, with no output register between. Reads and writes may alternate on every cycle with no idle cycle when the bus changes direction. To make that possible, a write's data arrives one active edge after its address. The word is held in a pending-write register and commits to the array on the next active edge. Reads of that address see the pending bytes in the meantime.

An access starts on a load cycle, when `adv_ld` is low. The two low address bits then run through a four-beat burst on advance cycles, when `adv_ld` is high. The burst order is linear or interleaved, chosen by the `mode` pin at load time. The word is divided into byte lanes of nine bits, each with its own write strobe. Three chip enables of mixed polarity allow depth expansion. `cke_n` freezes the whole block, `oe_n` gates the output and `zz` powers the block down. The data bus is split into `din` and `dout`, and `dout_en` tells when the bus would be driven.

Top module: `fsram_ft`

## Requirements
- R1: On a selected load cycle with `we_n` high, a read starts. After that edge, `dout` shows the word at `addr` and `dout_en` is high while `oe_n` is low and `zz` is low.
- R2: On a selected load cycle with `we_n` low, a write starts. The data is taken from `din` on the next active edge, and later reads of that address return it.
- R3: Bit `bw_n[i]`, sampled with the write's address, is active low. It controls whether data bits `[9i+8:9i]` are written. Lanes whose strobe is high keep their stored content.
- R4: A read of an address may follow on the very next cycle after that address's write-data edge. It returns the new data with no idle cycle between.
- R5: With `mode` low at load, advance cycles step the two low address bits through start+k mod 4. The upper bits stay fixed.
- R6: With `mode` high at load, advance cycles give the two low address bits as start XOR k, for k = 1, 2, 3.
- R7: The block is selected only when `ce_n`=0, `ce2`=1 and `ce2_n`=0. Any other load is a deselect with `dout_en` low. Advance cycles after a deselect stay deselected.
- R8: While `cke_n` is high, every input is ignored. The burst position, the current operation, the pending write and the output all hold.
- R9: `oe_n` high forces `dout_en` low and `dout` to zero, without disturbing the access in progress.
- R10: An active edge with `zz` high starts no access and ends any burst. The output is disabled, and the array and a pending write are kept.
- R11: After reset, no access is active, `dout_en` is low and no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| cke_n | input | 1 | Clock enable, active low; high suspends the block |
| adv_ld | input | 1 | Low loads a new address, high advances the burst |
| we_n | input | 1 | Low on a load cycle starts a write |
| bw_n | input | LANES | Per-lane write strobes, active low |
| ce_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce2_n | input | 1 | Chip enable, active low |
| mode | input | 1 | Burst order at load: 1 interleaved, 0 linear |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| zz | input | 1 | Power-down, active high |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data, taken one active edge after the write's address |
| dout | output | DATA_W | Read data, zero when not driven |
| dout_en | output | 1 | High when `dout` would drive the bus |

## Verification
The bench builds the block with ADDR_W=5, LANES=4 and LANE_W=9, which gives a 32-word array of 36-bit words. The array is small enough to be filled completely by writes, so every later read compares against known content. Burst start offsets of 1, 2 and 3 fall inside several four-word groups, so both orders are seen wrapping within a group. With four lanes, a strobe pattern can mix written and kept lanes in one word. It is applied to a word whose value is still pending, and read again after it commits.

// File: rtl/fsram_pkg.sv
package fsram_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } fsram_op_e;

    localparam int BURST_W = 2;

endpackage

// File: rtl/fsram_burst.sv
module fsram_burst
    import fsram_pkg::*;
#(
    parameter int STEP_W = BURST_W
) (
    input  logic [STEP_W-1:0] start,
    input  logic [STEP_W-1:0] step,
    input  logic              ilv,
    output logic [STEP_W-1:0] ofs
);

    always_comb begin
        if (ilv) begin
            ofs = start ^ step;
        end else begin
            ofs = start + step;
        end
    end

endmodule

// File: rtl/fsram_array.sv
module fsram_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DEPTH  = 1 << ADDR_W,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LANES-1:0]  wr_lane,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cell_q [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_lane[g]) begin
                cell_q[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        assign rd_data[g*LANE_W +: LANE_W] = cell_q[rd_addr];
    end

endmodule

// File: rtl/fsram_bypass.sv
module fsram_bypass #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic [DATA_W-1:0] arr_word,
    input  logic              hit,
    input  logic [LANES-1:0]  pend_lane,
    input  logic [DATA_W-1:0] pend_word,
    output logic [DATA_W-1:0] merged
);

    for (genvar g = 0; g < LANES; g++) begin : g_mux
        assign merged[g*LANE_W +: LANE_W] = (hit && pend_lane[g])
                                            ? pend_word[g*LANE_W +: LANE_W]
                                            : arr_word[g*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/fsram_ft.sv
module fsram_ft
    import fsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke_n,
    input  logic              adv_ld,
    input  logic              we_n,
    input  logic [LANES-1:0]  bw_n,
    input  logic              ce_n,
    input  logic              ce2,
    input  logic              ce2_n,
    input  logic              mode,
    input  logic              oe_n,
    input  logic              zz,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    localparam int HI_W = ADDR_W - BURST_W;

    typedef struct packed {
        fsram_op_e          op;
        logic [ADDR_W-1:0]  base;
        logic [BURST_W-1:0] step;
        logic               ilv;
        logic [LANES-1:0]   lane;
        logic               pv;
        logic [ADDR_W-1:0]  pa;
        logic [LANES-1:0]   pl;
        logic [DATA_W-1:0]  pd;
    } fsram_st_t;

    fsram_st_t          s_d, s_q;
    logic               sel;
    logic               arr_we;
    logic [BURST_W-1:0] ofs;
    logic [ADDR_W-1:0]  cur_addr;
    logic [DATA_W-1:0]  arr_word;
    logic [DATA_W-1:0]  merged;
    logic               hit;

    fsram_burst #(.STEP_W(BURST_W)) u_burst (
        .start (s_q.base[BURST_W-1:0]),
        .step  (s_q.step),
        .ilv   (s_q.ilv),
        .ofs   (ofs)
    );

    assign cur_addr = {s_q.base[ADDR_W-1 -: HI_W], ofs};
    assign sel      = !ce_n && ce2 && !ce2_n;

    always_comb begin
        s_d    = s_q;
        arr_we = 1'b0;
        if (!cke_n) begin
            arr_we = s_q.pv;
            s_d.pv = 1'b0;
            if (s_q.op == OP_WRITE) begin
                s_d.pv = 1'b1;
                s_d.pa = cur_addr;
                s_d.pl = s_q.lane;
                s_d.pd = din;
            end
            s_d.lane = ~bw_n;
            if (zz) begin
                s_d.op = OP_IDLE;
            end else if (!adv_ld) begin
                if (sel) begin
                    s_d.op   = we_n ? OP_READ : OP_WRITE;
                    s_d.base = addr;
                    s_d.step = '0;
                    s_d.ilv  = mode;
                end else begin
                    s_d.op = OP_IDLE;
                end
            end else begin
                s_d.step = s_q.step + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    fsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .wr_en   (arr_we),
        .wr_addr (s_q.pa),
        .wr_lane (s_q.pl),
        .wr_data (s_q.pd),
        .rd_addr (cur_addr),
        .rd_data (arr_word)
    );

    assign hit = s_q.pv && (s_q.pa == cur_addr);

    fsram_bypass #(.LANES(LANES), .LANE_W(LANE_W)) u_bypass (
        .arr_word  (arr_word),
        .hit       (hit),
        .pend_lane (s_q.pl),
        .pend_word (s_q.pd),
        .merged    (merged)
    );

    assign dout_en = (s_q.op == OP_READ) && !oe_n && !zz;
    assign dout    = dout_en ? merged : '0;

    AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !zz && !adv_ld && sel) |=> (cur_addr == $past(addr))); // R1

    AST_WRITE_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && s_q.op == OP_WRITE) |=> s_q.pv); // R2

    AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !zz && adv_ld) |=> (s_q.step == $past(s_q.step) + 2'd1)); // R5

    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !zz && !adv_ld && !sel) |=> !dout_en); // R7

    AST_SUSPEND_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> ($stable(cur_addr) && $stable(s_q.op) && $stable(s_q.pv))); // R8

    AST_POWERDOWN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && zz) |=> (s_q.op == OP_IDLE)); // R10

endmodule

// File: tb/tb_fsram_ft.sv
`timescale 1ns/1ps
module tb_fsram_ft;

    localparam int AW = 5;
    localparam int LN = 4;
    localparam int LW = 9;
    localparam int DW = LN * LW;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cke_n = 1'b0, adv_ld = 1'b0, we_n = 1'b1;
    logic [LN-1:0] bw_n = '0;
    logic ce_n = 1'b1, ce2 = 1'b1, ce2_n = 1'b0;
    logic mode = 1'b0, oe_n = 1'b0, zz = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic dout_en;

    always #4 clk = ~clk;

    fsram_ft #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) dut (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .adv_ld(adv_ld), .we_n(we_n),
        .bw_n(bw_n), .ce_n(ce_n), .ce2(ce2), .ce2_n(ce2_n), .mode(mode),
        .oe_n(oe_n), .zz(zz), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
    );

    // behavioural reference
    logic [DW-1:0] ref_mem [DEPTH];
    int            r_op = 0;      // 0 idle, 1 read, 2 write
    logic [AW-1:0] r_base = '0;
    int            r_k = 0;
    logic          r_ilv = 1'b0;
    logic [LN-1:0] r_bwn = '0;
    int            nvec = 0;
    int            nfail = 0;
    string         cur_req = "R11";

    function automatic logic [AW-1:0] r_addr();
        logic [1:0] lo;
        lo = r_ilv ? (r_base[1:0] ^ 2'(r_k)) : 2'((int'(r_base[1:0]) + r_k) % 4);
        return {r_base[AW-1:2], lo};
    endfunction

    function automatic logic [DW-1:0] pat(int i);
        return {4'(i + 5), 32'(i * 32'h9E37_79B1)};
    endfunction

    task automatic model_edge();
        if (!cke_n) begin
            if (r_op == 2) begin
                for (int l = 0; l < LN; l++) begin
                    if (!r_bwn[l]) ref_mem[r_addr()][l*LW +: LW] = din[l*LW +: LW];
                end
            end
            r_bwn = bw_n;
            if (zz) r_op = 0;
            else if (!adv_ld) begin
                if (!ce_n && ce2 && !ce2_n) begin
                    r_op = we_n ? 1 : 2;
                    r_base = addr;
                    r_k = 0;
                    r_ilv = mode;
                end else r_op = 0;
            end else r_k = (r_k + 1) % 4;
        end
    endtask

    task automatic compare();
        logic          e_en;
        logic [DW-1:0] e_d;
        e_en = (r_op == 1) && !oe_n && !zz;
        e_d  = e_en ? ref_mem[r_addr()] : '0;
        nvec++;
        if (dout_en !== e_en || dout !== e_d) begin
            nfail++;
            $display("FAIL %s: dout_en=%0b dout=%h expected dout_en=%0b dout=%h",
                     cur_req, dout_en, dout, e_en, e_d);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic cyc(input string req, input logic l_adv, input logic l_we,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
        cur_req = req;
        adv_ld  = l_adv;
        we_n    = l_we;
        addr    = a;
        din     = d;
        tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R11: after reset nothing is driven
        cur_req = "R11";
        compare();
        cyc("R11", 1'b0, 1'b1, 5'd0, '0);

        // R2: fill the array with single writes back to back
        ce_n = 1'b0;
        for (int i = 0; i < DEPTH; i++) cyc("R2", 1'b0, 1'b0, AW'(i), pat(i - 1));
        cyc("R2", 1'b0, 1'b1, 5'd31, pat(DEPTH - 1));
        // R1: flow-through reads of every word
        for (int i = 0; i < DEPTH; i++) cyc("R1", 1'b0, 1'b1, AW'(i), '0);

        // R4: write then read of the same word on the next cycle
        for (int i = 0; i < 6; i++) begin
            cyc("R4", 1'b0, 1'b0, AW'(3 * i + 1), '0);
            cyc("R4", 1'b0, 1'b1, AW'(3 * i + 1), pat(100 + i));
        end
        cyc("R4", 1'b0, 1'b0, 5'd2, '0);
        cyc("R4", 1'b0, 1'b0, 5'd3, pat(200));
        cyc("R4", 1'b0, 1'b1, 5'd2, pat(201));
        cyc("R4", 1'b0, 1'b1, 5'd3, '0);

        // R3: partial lane write, read while pending and after commit
        bw_n = 4'b0101;
        cyc("R3", 1'b0, 1'b0, 5'd9, '0);
        bw_n = 4'b0000;
        cyc("R3", 1'b0, 1'b1, 5'd9, {DW{1'b1}});
        cyc("R3", 1'b0, 1'b1, 5'd9, '0);
        cyc("R3", 1'b0, 1'b1, 5'd8, '0);
        cyc("R3", 1'b0, 1'b1, 5'd9, '0);

        // R5: linear bursts, read and write
        mode = 1'b0;
        cyc("R5", 1'b0, 1'b1, 5'd13, '0);
        for (int k = 0; k < 3; k++) cyc("R5", 1'b1, 1'b0, 5'd0, '0);
        cyc("R5", 1'b0, 1'b0, 5'd6, '0);
        for (int k = 0; k < 3; k++) cyc("R5", 1'b1, 1'b1, 5'd0, pat(300 + k));
        cyc("R5", 1'b0, 1'b1, 5'd6, pat(303));
        for (int k = 0; k < 3; k++) cyc("R5", 1'b1, 1'b1, 5'd0, '0);

        // R6: interleaved bursts from start offsets 2 and 3
        mode = 1'b1;
        cyc("R6", 1'b0, 1'b1, 5'd14, '0);
        for (int k = 0; k < 3; k++) cyc("R6", 1'b1, 1'b1, 5'd0, '0);
        cyc("R6", 1'b0, 1'b1, 5'd23, '0);
        mode = 1'b0;
        for (int k = 0; k < 3; k++) cyc("R6", 1'b1, 1'b1, 5'd0, '0);

        // R7: each enable wrong in turn, then advance
        ce_n = 1'b1;
        cyc("R7", 1'b0, 1'b1, 5'd4, '0);
        cyc("R7", 1'b1, 1'b1, 5'd0, '0);
        ce_n = 1'b0; ce2 = 1'b0;
        cyc("R7", 1'b0, 1'b1, 5'd4, '0);
        cyc("R7", 1'b1, 1'b1, 5'd0, '0);
        ce2 = 1'b1; ce2_n = 1'b1;
        cyc("R7", 1'b0, 1'b1, 5'd4, '0);
        cyc("R7", 1'b1, 1'b1, 5'd0, '0);
        ce2_n = 1'b0;
        cyc("R7", 1'b0, 1'b1, 5'd4, '0);

        // R8: suspend in a burst and with a write pending its data
        cyc("R8", 1'b0, 1'b1, 5'd20, '0);
        cyc("R8", 1'b1, 1'b1, 5'd0, '0);
        cke_n = 1'b1;
        for (int k = 0; k < 3; k++) cyc("R8", 1'b0, 1'b0, 5'd0, pat(400 + k));
        cke_n = 1'b0;
        cyc("R8", 1'b1, 1'b1, 5'd0, '0);
        cyc("R8", 1'b1, 1'b1, 5'd0, '0);
        cyc("R8", 1'b0, 1'b0, 5'd3, '0);
        cke_n = 1'b1;
        cyc("R8", 1'b0, 1'b1, 5'd7, pat(410));
        cyc("R8", 1'b1, 1'b0, 5'd7, pat(411));
        cke_n = 1'b0;
        cyc("R8", 1'b0, 1'b1, 5'd3, pat(412));
        cyc("R8", 1'b0, 1'b1, 5'd3, '0);

        // R9: output enable gating within a read burst
        cyc("R9", 1'b0, 1'b1, 5'd5, '0);
        oe_n = 1'b1;
        cyc("R9", 1'b1, 1'b1, 5'd0, '0);
        oe_n = 1'b0;
        cyc("R9", 1'b1, 1'b1, 5'd0, '0);

        // R10: power-down blocks new accesses, keeps pending write and array
        cyc("R10", 1'b0, 1'b1, 5'd8, '0);
        zz = 1'b1;
        cyc("R10", 1'b0, 1'b0, 5'd8, pat(500));
        zz = 1'b0;
        cyc("R10", 1'b1, 1'b1, 5'd0, pat(501));
        cyc("R10", 1'b0, 1'b1, 5'd8, '0);
        cyc("R10", 1'b0, 1'b0, 5'd10, '0);
        zz = 1'b1;
        cyc("R10", 1'b0, 1'b1, 5'd10, pat(502));
        zz = 1'b0;
        cyc("R10", 1'b0, 1'b1, 5'd10, '0);
        cyc("R10", 1'b0, 1'b1, 5'd10, '0);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule